// File: doc/BRIEF.md
# Shadowed Multi-Latch Write Controller

This block drives a small bank of external byte-wide latches that share one data bus. Each latch has its own active-low load strobe. The latches cannot be read back, so the block keeps an internal shadow copy of every latch. Each request merges a value under a per-bit mask into the shadow of the chosen latch. The merged byte then goes out on the bus, and a three-phase timed strobe sequence loads it into that latch.

A requester offers one request at a time through a valid/ready handshake. A request names a latch, a value and a mask. It can instead run in single-bit mode, which sets or clears one bit and leaves the value and mask inputs unused. An index that names no existing latch is refused. The refusal is a one-cycle error pulse, and the bus, the strobes and the shadows stay as they were. The length of one settle interval is a parameter counted in clock cycles (about one microsecond in the intended use).

Top module: `latch_bank_writer`

## Requirements
- R1: After reset every shadow holds zero, the bus reads 0x00, all strobes are high (0xF), busy is low and ready is high.
- R2: An accepted write makes the bus carry (shadow AND NOT mask) OR (value AND mask). The result becomes the new shadow of that latch.
- R3: A write to one latch leaves the shadows of the other latches unchanged.
- R4: During the strobe phase the strobe word equals 0xF XOR (1 << index), bit i belonging to latch i. At no time is more than one strobe low.
- R5: The bus settles SETTLE_CYC cycles before the strobe falls. The strobe stays low for SETTLE_CYC cycles. It then stays high for SETTLE_CYC cycles before the write completes.
- R6: busy is high for exactly 3*SETTLE_CYC cycles, from the cycle after acceptance. ready is low whenever busy is high.
- R7: done pulses high for exactly one cycle, in the cycle right after busy falls.
- R8: An index of LATCH_N or above gives an err pulse one cycle after acceptance. It causes no strobe, no busy, no done, no bus change and no shadow change.
- R9: In single-bit mode the effective value is state << bit and the effective mask is 1 << bit. The value and mask inputs are ignored in this mode.
- R10: A request offered while busy is not accepted and changes no shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_idx_i | input | IDX_W | Latch index |
| req_bit_mode_i | input | 1 | 1: single-bit operation |
| req_bit_sel_i | input | log2(DATA_W) | Bit position in single-bit mode |
| req_bit_state_i | input | 1 | Bit value in single-bit mode |
| req_value_i | input | DATA_W | Write value |
| req_mask_i | input | DATA_W | Write mask, 1 = bit taken from value |
| bus_data_o | output | DATA_W | Shared latch data bus |
| strobe_no | output | LATCH_N | Per-latch load strobes, active low |
| busy_o | output | 1 | Strobe sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse for a bad index |

## Verification
The handshake is taken at an edge E0. The merged byte and busy appear at the negedge after E0. The strobe is low at the negedges that follow edges E0+S to E0+2S-1, and busy drops at E0+3S. Done is high only at the negedge after E0+3S. The bench walks the negedges after E0 by index and compares bus, strobes, busy and done against these windows at each one. A refused request is checked at the negedge after E0 for err and for an untouched bus. A later masked-off write to each latch reveals its shadow on the bus.

// File: rtl/latch_bus_pkg.sv
package latch_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lbw_req_decode.sv
module lbw_req_decode #(
  parameter int LATCH_N = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int SEL_W  = $clog2(LATCH_N)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bit_mode_i,
  input  logic [BIT_W-1:0]  bit_sel_i,
  input  logic              bit_state_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              idx_ok_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] eff_value_o,
  output logic [DATA_W-1:0] eff_mask_o
);
  logic [DATA_W-1:0] bit_mask;

  assign idx_ok_o = (idx_i < IDX_W'(LATCH_N));
  assign sel_o    = idx_i[SEL_W-1:0];
  assign bit_mask = DATA_W'(1) << bit_sel_i;

  always_comb begin
    if (bit_mode_i) begin
      eff_mask_o  = bit_mask;
      eff_value_o = bit_state_i ? bit_mask : '0;
    end else begin
      eff_mask_o  = mask_i;
      eff_value_o = value_i;
    end
  end
endmodule

// File: rtl/lbw_shadow_bank.sv
module lbw_shadow_bank #(
  parameter int LATCH_N = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(LATCH_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] shadow_q [LATCH_N];

  assign merged_o = (shadow_q[sel_i] & ~mask_i) | (value_i & mask_i);

  for (genvar g = 0; g < LATCH_N; g++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
      end else if (wr_en_i && (sel_i == SEL_W'(g))) begin
        shadow_q[g] <= merged_o;
      end
    end
  end
endmodule

// File: rtl/lbw_sequencer.sv
module lbw_sequencer
  import latch_bus_pkg::*;
#(
  parameter int LATCH_N    = 4,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 50,
  localparam int SEL_W     = $clog2(LATCH_N),
  localparam int CNT_W     = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               reject_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               idle_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [DATA_W-1:0]  bus_data_o,
  output logic [LATCH_N-1:0] strobe_no
);
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              last_tick;

  assign last_tick = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign sel_d     = start_i ? sel_i : sel_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i)   state_d = ST_SETUP;
      ST_SETUP:  if (last_tick) state_d = ST_STROBE;
      ST_STROBE: if (last_tick) state_d = ST_HOLD;
      ST_HOLD:   if (last_tick) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sel_q      <= '0;
      bus_data_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      done_o  <= (state_q == ST_HOLD) && last_tick;
      err_o   <= reject_i;
      if (start_i) bus_data_o <= data_i;
      if (state_q == ST_IDLE || last_tick) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
    end
  end

  // one register per strobe line, low only while in the strobe phase
  for (genvar g = 0; g < LATCH_N; g++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_no[g] <= 1'b1;
      else         strobe_no[g] <= !((state_d == ST_STROBE) && (sel_d == SEL_W'(g)));
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign busy_o = !idle_o;
endmodule

// File: rtl/latch_bank_writer.sv
module latch_bank_writer #(
  parameter int LATCH_N    = 4,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 3,
  parameter int SETTLE_CYC = 50,
  localparam int BIT_W     = $clog2(DATA_W),
  localparam int SEL_W     = $clog2(LATCH_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic               req_bit_mode_i,
  input  logic [BIT_W-1:0]   req_bit_sel_i,
  input  logic               req_bit_state_i,
  input  logic [DATA_W-1:0]  req_value_i,
  input  logic [DATA_W-1:0]  req_mask_i,
  output logic [DATA_W-1:0]  bus_data_o,
  output logic [LATCH_N-1:0] strobe_no,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  logic              idx_ok, idle, accept, start, reject;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] eff_value, eff_mask, merged;

  assign req_ready_o = idle;
  assign accept      = req_valid_i && idle;
  assign start       = accept && idx_ok;
  assign reject      = accept && !idx_ok;

  lbw_req_decode #(
    .LATCH_N(LATCH_N), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_decode (
    .idx_i       (req_idx_i),
    .bit_mode_i  (req_bit_mode_i),
    .bit_sel_i   (req_bit_sel_i),
    .bit_state_i (req_bit_state_i),
    .value_i     (req_value_i),
    .mask_i      (req_mask_i),
    .idx_ok_o    (idx_ok),
    .sel_o       (sel),
    .eff_value_o (eff_value),
    .eff_mask_o  (eff_mask)
  );

  lbw_shadow_bank #(
    .LATCH_N(LATCH_N), .DATA_W(DATA_W)
  ) i_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (start),
    .sel_i    (sel),
    .value_i  (eff_value),
    .mask_i   (eff_mask),
    .merged_o (merged)
  );

  lbw_sequencer #(
    .LATCH_N(LATCH_N), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .reject_i   (reject),
    .sel_i      (sel),
    .data_i     (merged),
    .idle_o     (idle),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .bus_data_o (bus_data_o),
    .strobe_no  (strobe_no)
  );
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
  parameter int LATCH_N    = 4,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 50
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_ready_o,
  input logic [DATA_W-1:0]  bus_data_o,
  input logic [LATCH_N-1:0] strobe_no,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o
);
  logic        all_hi;
  int unsigned low_cnt;

  assign all_hi = &strobe_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= 0;
    else if (!all_hi) low_cnt <= low_cnt + 1;
    else              low_cnt <= 0;
  end

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~strobe_no));

  a_r5_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_hi |-> $stable(bus_data_o));

  a_r5_strobe_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_hi && !$past(all_hi)) |-> (low_cnt == SETTLE_CYC));

  a_r6_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (all_hi && !busy_o && !done_o && $stable(bus_data_o)));
endmodule

bind latch_bank_writer lbw_checker #(
  .LATCH_N(LATCH_N), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
) i_lbw_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_data_o  (bus_data_o),
  .strobe_no   (strobe_no),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_latch_bank_writer.sv
module test_latch_bank_writer;
  localparam int S = 4;

  typedef struct packed {
    logic [2:0] idx;
    logic       bm;
    logic [2:0] bsel;
    logic       bst;
    logic [7:0] val;
    logic [7:0] msk;
    logic [7:0] exp;
    logic       err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 3'd0, 1'b0, 8'hA5, 8'hFF, 8'hA5, 1'b0},
    '{3'd1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h0F, 8'hA0, 1'b0},
    '{3'd2, 1'b0, 3'd0, 1'b0, 8'h3C, 8'hF0, 8'h30, 1'b0},
    '{3'd1, 1'b0, 3'd0, 1'b0, 8'hFF, 8'h00, 8'hA0, 1'b0},
    '{3'd0, 1'b1, 3'd7, 1'b1, 8'hFF, 8'hFF, 8'h80, 1'b0},
    '{3'd0, 1'b1, 3'd0, 1'b1, 8'h00, 8'h00, 8'h81, 1'b0},
    '{3'd0, 1'b1, 3'd7, 1'b0, 8'hFF, 8'hFF, 8'h01, 1'b0},
    '{3'd3, 1'b0, 3'd0, 1'b0, 8'h5A, 8'h3C, 8'h18, 1'b0},
    '{3'd5, 1'b0, 3'd0, 1'b0, 8'hFF, 8'hFF, 8'h18, 1'b1},
    '{3'd3, 1'b0, 3'd0, 1'b0, 8'hFF, 8'hC3, 8'hDB, 1'b0},
    '{3'd2, 1'b1, 3'd1, 1'b1, 8'h00, 8'hFF, 8'h32, 1'b0},
    '{3'd7, 1'b0, 3'd0, 1'b0, 8'h00, 8'hFF, 8'h32, 1'b1}
  };
  string tag [NV] = '{"R2", "R2", "R3", "R3", "R9", "R9", "R9", "R2",
                      "R8", "R3", "R9", "R8"};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [2:0] req_idx_i = '0;
  logic       req_bit_mode_i = 1'b0;
  logic [2:0] req_bit_sel_i = '0;
  logic       req_bit_state_i = 1'b0;
  logic [7:0] req_value_i = '0;
  logic [7:0] req_mask_i = '0;
  logic [7:0] bus_data_o;
  logic [3:0] strobe_no;
  logic       busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  latch_bank_writer #(.SETTLE_CYC(S)) i_latch_bank_writer (.*);

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_idx_i       = v.idx;
    req_bit_mode_i  = v.bm;
    req_bit_sel_i   = v.bsel;
    req_bit_state_i = v.bst;
    req_value_i     = v.val;
    req_mask_i      = v.msk;
    req_valid_i     = 1'b1;
  endtask

  // at a negedge with the block idle: offer, accept at next posedge, track
  task automatic run_req(input vec_t v, input string req);
    logic [3:0] sb;
    drive(v);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (v.err) begin
      check(err_o == 1'b1, "R8", "err pulse", 32'(err_o), 1);
      check(strobe_no == 4'hF && !busy_o, "R8", "no activity",
            32'({busy_o, strobe_no}), 32'h0F);
      check(bus_data_o == v.exp, "R8", "bus unchanged", 32'(bus_data_o), 32'(v.exp));
      @(negedge clk_i);
      check(err_o == 1'b0 && !done_o, "R8", "err single cycle", 32'({err_o, done_o}), 0);
      return;
    end
    check(bus_data_o == v.exp, req, "merged data", 32'(bus_data_o), 32'(v.exp));
    check(!req_ready_o, "R6", "ready low while busy", 32'(req_ready_o), 0);
    for (int j = 0; j <= 3 * S + 1; j++) begin
      if (j > 0) @(negedge clk_i);
      sb = (j >= S && j < 2 * S) ? (4'hF ^ (4'd1 << v.idx)) : 4'hF;
      check(strobe_no == sb, (j >= S && j < 2 * S) ? "R4" : "R5", "strobe",
            32'(strobe_no), 32'(sb));
      check(busy_o == (j < 3 * S), "R6", "busy", 32'(busy_o), 32'(j < 3 * S));
      check(done_o == (j == 3 * S), "R7", "done", 32'(done_o), 32'(j == 3 * S));
      check(bus_data_o == v.exp, "R5", "bus held", 32'(bus_data_o), 32'(v.exp));
      check(!err_o, "R8", "no err on good index", 32'(err_o), 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(bus_data_o == 8'h00 && strobe_no == 4'hF, "R1", "bus/strobe at reset",
          32'({bus_data_o, strobe_no}), 32'h00F);
    check(!busy_o && !done_o && !err_o, "R1", "flags at reset",
          32'({busy_o, done_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1", "ready after reset", 32'(req_ready_o), 1);

    for (int i = 0; i < NV; i++) run_req(VEC[i], tag[i]);

    // R10: request offered during busy is dropped
    v = '{3'd0, 1'b0, 3'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0};
    drive(v);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    drive('{3'd1, 1'b0, 3'd0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0});
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(bus_data_o == 8'hFF, "R10", "busy request ignored", 32'(bus_data_o), 32'hFF);
    wait (done_o);
    @(negedge clk_i);
    // latch 1 shadow must still be A0 (read out via masked-off write)
    run_req('{3'd1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 8'hA0, 1'b0}, "R10");

    // R1: async reset clears all shadows
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 4; k++)
      run_req('{3'(k), 1'b0, 3'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b0}, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule